// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM with Write-Hold Input

This block is a 2048-word by 16-bit memory with two fully independent access ports, left and right, sharing one clock. Each port can write or read any word. Within a single access, every 8-bit lane of the word has its own write/read direction, so one lane can be stored while the other is read back.

The block makes no arbitration decision. Each port has an active-low hold input that a separate arbiter, elsewhere in the system, drives when it detects a conflict. While hold is low, nothing from that port reaches the array, and that port's read lanes are reported as not valid. Tying a hold input high gives plain operation. Tying it low makes that port read-only-inhibited and write-protected.

Output data is never tri-stated. Each read lane has a valid flag, and a lane that is not valid returns zero. Read data and flags are registered and appear on the clock edge after the address is presented.

Top module: `dpram_bytelane`

## Requirements
- R1: While a port's select (`*_sel_n`) is high, that port stores nothing, and on the next cycle both of its valid flags are 0.
- R2: With select low and hold high, each lane whose write control bit is 0 stores its write byte at the addressed word. Bit 0 is the lower byte [7:0] and bit 1 is the upper byte [15:8]. A lane whose control bit is 1 leaves its stored byte unchanged.
- R3: With select low, output enable low and hold high, each lane whose write control bit is 1 shows, one cycle later, its valid flag at 1 and the byte stored in that lane before that clock edge.
- R4: A lane that is not read validly has its valid flag at 0 and its output byte at 0. This includes the case where output enable is high.
- R5: In one access, one lane may be written while the other lane is read. The read lane returns its previous content.
- R6: While a port's hold input is low, no lane of that port is stored.
- R7: While a port's hold input is low, both of that port's valid flags are 0 on the next cycle.
- R8: When both ports write the same lane of the same word on the same edge, the left port's byte is stored.
- R9: A read on one port returns the content from before any write the other port makes to the same word on the same edge.
- R10: While reset is low, nothing is stored, and on the next cycle all valid flags and read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| lft_sel_n | input | 1 | Left port select, active low |
| lft_out_en_n | input | 1 | Left port read output enable, active low |
| lft_wr_n | input | 2 | Left per-lane direction: 0 write, 1 read |
| lft_hold_n | input | 1 | Left write hold, active low |
| lft_addr | input | 11 | Left word address |
| lft_wdata | input | 16 | Left write data |
| lft_rdata | output | 16 | Left read data, zero in invalid lanes |
| lft_rvalid | output | 2 | Left per-lane read valid |
| rgt_sel_n | input | 1 | Right port select, active low |
| rgt_out_en_n | input | 1 | Right port read output enable, active low |
| rgt_wr_n | input | 2 | Right per-lane direction: 0 write, 1 read |
| rgt_hold_n | input | 1 | Right write hold, active low |
| rgt_addr | input | 11 | Right word address |
| rgt_wdata | input | 16 | Right write data |
| rgt_rdata | output | 16 | Right read data, zero in invalid lanes |
| rgt_rvalid | output | 2 | Right per-lane read valid |

## Verification
The embedded properties check on every cycle that:
- the valid flags follow select, output enable, hold and the lane direction one cycle later;
- invalid lanes are zeroed;
- reset clears the outputs;
- the left byte lands in the array after every left write.

Only the bench's scenarios show:
- which bytes actually end up stored;
- that held or deselected writes leave memory untouched;
- mixed-lane accesses;
- read-before-write between the two ports.

The bench shows these by replaying every access against a behavioural memory model, including a dense random phase confined to eight addresses.

// File: rtl/dpr_pkg.sv
// Package: shared constants and types for the byte-lane dual-port RAM.
// Assumes byte lanes of eight bits and exactly two ports.
package dpr_pkg;
    localparam int LANE_W = 8;
    localparam int NPORT  = 2;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;
endpackage

// File: rtl/dpr_port_decode.sv
// Module: dpr_port_decode
// Turns one port's raw controls into per-lane write and read requests.
// Assumes active-low controls; hold low blocks writes and reads alike.
module dpr_port_decode #(
    parameter int LANES = 2
) (
    input  logic             sel_n,
    input  logic             out_en_n,
    input  logic [LANES-1:0] wr_n,
    input  logic             hold_n,
    output logic [LANES-1:0] wen,
    output logic [LANES-1:0] rden
);
    logic active;

    // Purpose: a port acts only when selected and not held.
    always_comb active = !sel_n && hold_n;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Purpose: a lane writes when its direction bit is 0, reads when 1 with output enabled.
        always_comb begin
            wen[l]  = active && !wr_n[l];
            rden[l] = active && wr_n[l] && !out_en_n;
        end
    end
endmodule

// File: rtl/dpr_store.sv
// Module: dpr_store
// Word array with per-lane writes from two ports and registered reads.
// Assumes the left port (index 0) wins same-lane, same-word write collisions,
// and that a read returns the content from before that edge's writes.
module dpr_store
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NPORT-1:0][ADDR_W-1:0]       addr,
    input  logic [NPORT-1:0][DATA_W-1:0]       wdata,
    input  logic [NPORT-1:0][DATA_W/LANE_W-1:0] wen,
    input  logic [NPORT-1:0][DATA_W/LANE_W-1:0] rden,
    output logic [NPORT-1:0][DATA_W-1:0]       raw,
    output logic [NPORT-1:0][DATA_W/LANE_W-1:0] vld
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: store lanes; the right port goes first, so the left port's later assignment wins.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int p = NPORT - 1; p >= 0; p--) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wen[p][l]) begin
                        mem[addr[p]][l*LANE_W +: LANE_W] <= wdata[p][l*LANE_W +: LANE_W];
                    end
                end
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        // Purpose: register the old word and the lane-valid flags for this port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw[p] <= '0;
                vld[p] <= '0;
            end else begin
                raw[p] <= mem[addr[p]];
                vld[p] <= rden[p];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        // R8: after a left lane write, that lane of the array holds the left byte.
        p_left_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && wen[SIDE_L][l]) |=>
            mem[$past(addr[SIDE_L])][l*LANE_W +: LANE_W] == $past(wdata[SIDE_L][l*LANE_W +: LANE_W]));
    end
endmodule

// File: rtl/dpr_lane_mask.sv
// Module: dpr_lane_mask
// Forces each output lane to zero unless its valid flag is set.
// Assumes raw data and flags arrive already registered.
module dpr_lane_mask
    import dpr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]        raw,
    input  logic [DATA_W/LANE_W-1:0] vld,
    output logic [DATA_W-1:0]        rdata
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Purpose: pass the lane through only when it is valid.
        always_comb rdata[l*LANE_W +: LANE_W] = vld[l] ? raw[l*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/dpram_bytelane.sv
// Module: dpram_bytelane (top)
// Two-port word memory with per-byte-lane direction and an external write hold per port.
// Assumes an arbiter outside the block drives the hold inputs; no arbitration happens here.
module dpram_bytelane
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lft_sel_n,
    input  logic                       lft_out_en_n,
    input  logic [DATA_W/LANE_W-1:0]   lft_wr_n,
    input  logic                       lft_hold_n,
    input  logic [ADDR_W-1:0]          lft_addr,
    input  logic [DATA_W-1:0]          lft_wdata,
    output logic [DATA_W-1:0]          lft_rdata,
    output logic [DATA_W/LANE_W-1:0]   lft_rvalid,
    input  logic                       rgt_sel_n,
    input  logic                       rgt_out_en_n,
    input  logic [DATA_W/LANE_W-1:0]   rgt_wr_n,
    input  logic                       rgt_hold_n,
    input  logic [ADDR_W-1:0]          rgt_addr,
    input  logic [DATA_W-1:0]          rgt_wdata,
    output logic [DATA_W-1:0]          rgt_rdata,
    output logic [DATA_W/LANE_W-1:0]   rgt_rvalid
);
    localparam int LANES = DATA_W / LANE_W;

    logic [NPORT-1:0]             sel_n, out_en_n, hold_n;
    logic [NPORT-1:0][LANES-1:0]  wr_n, wen, rden, vld;
    logic [NPORT-1:0][ADDR_W-1:0] addr;
    logic [NPORT-1:0][DATA_W-1:0] wdata, raw, rdata;

    // Purpose: gather the two ports' inputs into arrays indexed by side.
    always_comb begin
        sel_n    = {rgt_sel_n, lft_sel_n};
        out_en_n = {rgt_out_en_n, lft_out_en_n};
        hold_n   = {rgt_hold_n, lft_hold_n};
        wr_n     = {rgt_wr_n, lft_wr_n};
        addr     = {rgt_addr, lft_addr};
        wdata    = {rgt_wdata, lft_wdata};
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpr_port_decode #(.LANES(LANES)) u_dec (
            .sel_n    (sel_n[p]),
            .out_en_n (out_en_n[p]),
            .wr_n     (wr_n[p]),
            .hold_n   (hold_n[p]),
            .wen      (wen[p]),
            .rden     (rden[p])
        );

        dpr_lane_mask #(.DATA_W(DATA_W)) u_mask (
            .raw   (raw[p]),
            .vld   (vld[p]),
            .rdata (rdata[p])
        );

        // R1: a deselected port reports no valid lane on the next cycle.
        p_desel_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
            sel_n[p] |=> (vld[p] == '0));

        // R3: a selected, enabled, unheld access flags exactly its read lanes.
        p_read_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && !sel_n[p] && !out_en_n[p] && hold_n[p]) |=> (vld[p] == $past(wr_n[p])));

        // R4: with output enable high, no lane is valid.
        p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_en_n[p] |=> (vld[p] == '0));

        // R7: a held port reports no valid lane on the next cycle.
        p_hold_noread_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !hold_n[p] |=> (vld[p] == '0));

        // R10: reset clears flags and data on the following cycle.
        p_reset_clear_r10: assert property (@(posedge clk)
            !rst_n |=> (vld[p] == '0 && rdata[p] == '0));

        for (genvar l = 0; l < LANES; l++) begin : g_lchk
            // R4: a lane that is not valid outputs zero.
            p_idle_lane_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !vld[p][l] |-> (rdata[p][l*LANE_W +: LANE_W] == '0));
        end
    end

    dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wen   (wen),
        .rden  (rden),
        .raw   (raw),
        .vld   (vld)
    );

    // Purpose: route per-side outputs back to the named ports.
    always_comb begin
        lft_rdata  = rdata[SIDE_L];
        lft_rvalid = vld[SIDE_L];
        rgt_rdata  = rdata[SIDE_R];
        rgt_rvalid = vld[SIDE_R];
    end
endmodule

// File: tb/sim_dpram_bytelane.sv
module sim_dpram_bytelane;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic l_sel_n, l_oe_n, l_hold_n, r_sel_n, r_oe_n, r_hold_n;
    logic [1:0] l_wr_n, r_wr_n, l_rvalid, r_rvalid;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    dpram_bytelane u0 (
        .clk(clk), .rst_n(rst_n),
        .lft_sel_n(l_sel_n), .lft_out_en_n(l_oe_n), .lft_wr_n(l_wr_n), .lft_hold_n(l_hold_n),
        .lft_addr(l_addr), .lft_wdata(l_wdata), .lft_rdata(l_rdata), .lft_rvalid(l_rvalid),
        .rgt_sel_n(r_sel_n), .rgt_out_en_n(r_oe_n), .rgt_wr_n(r_wr_n), .rgt_hold_n(r_hold_n),
        .rgt_addr(r_addr), .rgt_wdata(r_wdata), .rgt_rdata(r_rdata), .rgt_rvalid(r_rvalid)
    );

    logic [DW-1:0] mdl [DEPTH];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural prediction of one port's registered output for the current inputs.
    function automatic logic [17:0] predict(input logic sel_n, input logic oe_n,
                                            input logic [1:0] wr_n, input logic hold_n,
                                            input logic [AW-1:0] a);
        logic [1:0] v;
        logic [15:0] d;
        for (int l = 0; l < 2; l++) v[l] = !sel_n && hold_n && !oe_n && wr_n[l];
        d[7:0]  = v[0] ? mdl[a][7:0]  : 8'h00;
        d[15:8] = v[1] ? mdl[a][15:8] : 8'h00;
        return {v, d};
    endfunction

    task automatic mwrite(input logic sel_n, input logic hold_n, input logic [1:0] wr_n,
                          input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (!sel_n && hold_n) begin
            if (!wr_n[0]) mdl[a][7:0]  = d[7:0];
            if (!wr_n[1]) mdl[a][15:8] = d[15:8];
        end
    endtask

    // One clock: predict, update model (right then left), clock, compare at negedge.
    task automatic step();
        logic [17:0] el, er;
        if (!rst_n) begin
            el = '0;
            er = '0;
        end else begin
            el = predict(l_sel_n, l_oe_n, l_wr_n, l_hold_n, l_addr);
            er = predict(r_sel_n, r_oe_n, r_wr_n, r_hold_n, r_addr);
            mwrite(r_sel_n, r_hold_n, r_wr_n, r_addr, r_wdata);
            mwrite(l_sel_n, l_hold_n, l_wr_n, l_addr, l_wdata);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R3 left per-cycle", {14'd0, l_rvalid, l_rdata}, {14'd0, el});
        chk("R3 right per-cycle", {14'd0, r_rvalid, r_rdata}, {14'd0, er});
    endtask

    task automatic idle();
        l_sel_n = 1; l_oe_n = 1; l_wr_n = 2'b11; l_hold_n = 1; l_addr = '0; l_wdata = '0;
        r_sel_n = 1; r_oe_n = 1; r_wr_n = 2'b11; r_hold_n = 1; r_addr = '0; r_wdata = '0;
    endtask

    task automatic lread(input logic [AW-1:0] a);
        idle(); l_sel_n = 0; l_oe_n = 0; l_addr = a;
        step();
    endtask

    task automatic rread(input logic [AW-1:0] a);
        idle(); r_sel_n = 0; r_oe_n = 0; r_addr = a;
        step();
    endtask

    initial begin
        logic [15:0] old;
        idle();
        rst_n = 0;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 'x;
        // R10: writes attempted during reset are dropped, outputs stay zero
        @(negedge clk);
        l_sel_n = 0; l_oe_n = 0; l_wr_n = 2'b00; l_addr = 11'd7; l_wdata = 16'hDEAD;
        repeat (3) step();
        chk("R10 reset valid", {30'd0, l_rvalid}, 32'd0);
        chk("R10 reset data", {16'd0, l_rdata}, 32'd0);
        idle();
        rst_n = 1;
        step();
        // fill: left the lower half, right the upper half
        for (int i = 0; i < DEPTH / 2; i++) begin
            l_sel_n = 0; l_wr_n = 2'b00; l_addr = AW'(i);
            l_wdata = 16'(i * 7) ^ 16'h5A3C;
            r_sel_n = 0; r_wr_n = 2'b00; r_addr = AW'(i + DEPTH / 2);
            r_wdata = 16'(i * 13) ^ 16'hC3A5;
            step();
        end
        // R10: address 7 holds fill data, not the reset-time write
        lread(11'd7);
        chk("R10 reset write dropped", {16'd0, l_rdata}, {16'd0, 16'(7 * 7) ^ 16'h5A3C});
        // R3: plain read of both lanes
        lread(11'd10);
        chk("R3 read both lanes", {14'd0, l_rvalid, l_rdata}, {14'd0, 2'b11, 16'(70) ^ 16'h5A3C});
        // R2: write only the upper lane
        old = mdl[20];
        idle(); l_sel_n = 0; l_wr_n = 2'b01; l_oe_n = 1; l_addr = 11'd20; l_wdata = 16'hABCD;
        step();
        lread(11'd20);
        chk("R2 upper lane only", {16'd0, l_rdata}, {16'd0, 8'hAB, old[7:0]});
        // R4: output enable high
        idle(); l_sel_n = 0; l_oe_n = 1; l_addr = 11'd20;
        step();
        chk("R4 oe high", {14'd0, l_rvalid, l_rdata}, 32'd0);
        // R1: deselected write attempt then readback
        old = mdl[21];
        idle(); r_wr_n = 2'b00; r_oe_n = 0; r_addr = 11'd21; r_wdata = 16'h1111;
        step();
        chk("R1 deselected flags", {30'd0, r_rvalid}, 32'd0);
        rread(11'd21);
        chk("R1 deselected no write", {16'd0, r_rdata}, {16'd0, old});
        // R5: lower lane written, upper lane read in one access
        old = mdl[30];
        idle(); l_sel_n = 0; l_oe_n = 0; l_wr_n = 2'b10; l_addr = 11'd30; l_wdata = 16'h77EE;
        step();
        chk("R5 mixed access", {14'd0, l_rvalid, l_rdata}, {14'd0, 2'b10, old[15:8], 8'h00});
        lread(11'd30);
        chk("R5 mixed stored", {16'd0, l_rdata}, {16'd0, old[15:8], 8'hEE});
        // R6 and R7: held port neither writes nor reads
        old = mdl[31];
        idle(); r_sel_n = 0; r_hold_n = 0; r_wr_n = 2'b00; r_addr = 11'd31; r_wdata = 16'h4242;
        step();
        idle(); r_sel_n = 0; r_hold_n = 0; r_oe_n = 0; r_addr = 11'd31;
        step();
        chk("R7 held read flags", {30'd0, r_rvalid}, 32'd0);
        rread(11'd31);
        chk("R6 held write dropped", {16'd0, r_rdata}, {16'd0, old});
        // R8: both ports write the same word; left wins
        idle();
        l_sel_n = 0; l_wr_n = 2'b00; l_addr = 11'd40; l_wdata = 16'hAAAA;
        r_sel_n = 0; r_wr_n = 2'b00; r_addr = 11'd40; r_wdata = 16'hBBBB;
        step();
        rread(11'd40);
        chk("R8 left wins", {16'd0, r_rdata}, {16'd0, 16'hAAAA});
        // R9: left write and right read of the same word on the same edge
        old = mdl[50];
        idle();
        l_sel_n = 0; l_wr_n = 2'b00; l_addr = 11'd50; l_wdata = 16'h9876;
        r_sel_n = 0; r_oe_n = 0; r_addr = 11'd50;
        step();
        chk("R9 read old word", {16'd0, r_rdata}, {16'd0, old});
        rread(11'd50);
        chk("R9 new word after", {16'd0, r_rdata}, {16'd0, 16'h9876});
        // dense random traffic over eight words
        for (int i = 0; i < 4000; i++) begin
            l_sel_n = 1'($urandom_range(0, 3) == 0); l_oe_n = 1'($urandom_range(0, 3) == 0);
            l_wr_n = 2'($urandom); l_hold_n = 1'($urandom_range(0, 4) != 0);
            l_addr = AW'($urandom_range(0, 7)); l_wdata = 16'($urandom);
            r_sel_n = 1'($urandom_range(0, 3) == 0); r_oe_n = 1'($urandom_range(0, 3) == 0);
            r_wr_n = 2'($urandom); r_hold_n = 1'($urandom_range(0, 4) != 0);
            r_addr = AW'($urandom_range(0, 7)); r_wdata = 16'($urandom);
            step();
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule